// File: doc/BRIEF.md
# Two-Level I/O Address Translation Walker

This block turns a 32-bit device-side virtual address into a physical address by reading two levels of translation entries from memory. A directory of 4096 four-byte entries starts at the address on `dir_base`. The top twelve address bits pick one directory entry, and that entry points to a 256-entry page table. The next eight bits pick one page entry, and that entry names a 4 KiB frame together with a 4-bit permission domain index. The low twelve bits pass through as the offset within the page.

A requester presents an address and its master number while `req_ready` is high. The walker then issues at most two single-word reads on its memory port, one at a time. One cycle later it returns a single response pulse that carries the physical address, the permission index and a status word. A missing entry at either level ends the walk early with a fault bit that is specific to that level. The faulting address and the requester are kept in that level's error registers. When `xlat_en` is low at acceptance, the address is returned unchanged and no memory read is made.

Top module: `iova_walker`

## Requirements
- R1: With translation enabled, the first read goes to `dir_base + 4*vaddr[31:20]`.
- R2: A directory entry counts as valid only when bits 1:0 are 2'b01, and bits 9:2 are ignored. With any other code the walk ends after one read. The response then has `rsp_status[16]`=1, `rsp_status[17]`=0, `rsp_paddr`=0 and `rsp_perm`=0.
- R3: For a valid directory entry D, the second read goes to `{D[31:10],10'b0} + 4*vaddr[19:12]`.
- R4: A page entry with bit 1 clear ends the walk. The response then has `rsp_status[17]`=1, `rsp_status[16]`=0, `rsp_paddr`=0 and `rsp_perm`=0.
- R5: For a page entry P with bit 1 set, the response has `rsp_paddr = {P[31:20+..12], vaddr[11:0]}` (P[31:12] then the offset), `rsp_perm = P[7:4]` and `rsp_status`=0.
- R6: On a fault, `rsp_status[NMASTER-1:0]` holds the one-hot master (bit m for master m). That level's error address register takes the request address and its error master register takes the same one-hot value. The other level's error registers keep their contents.
- R7: If `xlat_en` is low when a request is accepted, no memory read is made and `rsp_paddr` equals the request address, with `rsp_perm`=0 and `rsp_status`=0. The response comes in the cycle after acceptance.
- R8: `req_ready` is high only when the walker is idle. The address, master and enable are sampled at acceptance. Each accepted request gives exactly one single-cycle `rsp_valid` pulse. Only one memory read is outstanding at a time.
- R9: After reset, `req_ready`=1, `rsp_valid`=0, `mem_rd`=0 and all error registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xlat_en | input | 1 | Translation enable, sampled at request acceptance |
| dir_base | input | 32 | Physical address of the first-level directory |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_master | input | MW | Number of the requesting master |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_paddr | output | 32 | Translated physical address |
| rsp_perm | output | 4 | Permission domain index from the page entry |
| rsp_status | output | 32 | Bit 16 first-level fault, bit 17 second-level fault, low bits one-hot master on a fault |
| mem_rd | output | 1 | One-cycle memory read request |
| mem_addr | output | 32 | Byte address of the entry being read |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| err_vaddr_l1 | output | 32 | Address of the last first-level fault |
| err_vaddr_l2 | output | 32 | Address of the last second-level fault |
| err_who_l1 | output | NMASTER | One-hot master of the last first-level fault |
| err_who_l2 | output | NMASTER | One-hot master of the last second-level fault |

## Verification
The bench keeps its own sparse memory and uses it for both kinds of walk. Random addresses fall on a directory that mixes valid entries with every invalid low-bit code, and on page tables that mix present and absent pages. Read-address and result checks show whether the index and concatenation arithmetic is right, and whether each level's fault stays apart from the other's. Some directed cases pin down the boundaries: the top directory index, directory entries with junk in the ignored bits, and a page entry with only bit 0 set. Bypass requests with a random memory latency check that no reads are made and the response timing is right. Every request holds `req_valid` high with changing junk after acceptance and flips the enable during the walk, so a second acceptance or late sampling would show up.

// File: rtl/iova_walker.sv
module iova_walker #(
  parameter int NMASTER = 6,
  localparam int MW = (NMASTER > 1) ? $clog2(NMASTER) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               xlat_en,
  input  logic [31:0]        dir_base,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [31:0]        req_vaddr,
  input  logic [MW-1:0]      req_master,
  output logic               rsp_valid,
  output logic [31:0]        rsp_paddr,
  output logic [3:0]         rsp_perm,
  output logic [31:0]        rsp_status,
  output logic               mem_rd,
  output logic [31:0]        mem_addr,
  input  logic               mem_rvalid,
  input  logic [31:0]        mem_rdata,
  output logic [31:0]        err_vaddr_l1,
  output logic [31:0]        err_vaddr_l2,
  output logic [NMASTER-1:0] err_who_l1,
  output logic [NMASTER-1:0] err_who_l2
);

  typedef enum logic [2:0] {
    S_IDLE, S_L1_ISSUE, S_L1_WAIT, S_L2_ISSUE, S_L2_WAIT, S_RESP
  } state_t;

  state_t             st;
  logic [31:0]        va_q;
  logic [NMASTER-1:0] who_q;
  logic [21:0]        ptb_q;
  logic               f1_q, f2_q;

  assign req_ready = (st == S_IDLE);
  assign rsp_valid = (st == S_RESP);
  assign mem_rd    = (st == S_L1_ISSUE) || (st == S_L2_ISSUE);
  assign mem_addr  = (st == S_L1_ISSUE) ? dir_base + {18'b0, va_q[31:20], 2'b00}
                                        : {ptb_q, 10'b0} + {22'b0, va_q[19:12], 2'b00};
  assign rsp_status = ({30'b0, f2_q, f1_q} << 16)
                    | ((f1_q | f2_q) ? 32'(who_q) : 32'b0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= S_IDLE;
      va_q         <= '0;
      who_q        <= '0;
      ptb_q        <= '0;
      f1_q         <= 1'b0;
      f2_q         <= 1'b0;
      rsp_paddr    <= '0;
      rsp_perm     <= '0;
      err_vaddr_l1 <= '0;
      err_vaddr_l2 <= '0;
      err_who_l1   <= '0;
      err_who_l2   <= '0;
    end else begin
      unique case (st)
        S_IDLE: if (req_valid) begin
          va_q  <= req_vaddr;
          who_q <= NMASTER'(1) << req_master;
          f1_q  <= 1'b0;
          f2_q  <= 1'b0;
          if (xlat_en) begin
            st <= S_L1_ISSUE;
          end else begin
            rsp_paddr <= req_vaddr;
            rsp_perm  <= '0;
            st        <= S_RESP;
          end
        end
        S_L1_ISSUE: st <= S_L1_WAIT;
        S_L1_WAIT: if (mem_rvalid) begin
          if (mem_rdata[1:0] == 2'b01) begin
            ptb_q <= mem_rdata[31:10];
            st    <= S_L2_ISSUE;
          end else begin
            f1_q         <= 1'b1;
            rsp_paddr    <= '0;
            rsp_perm     <= '0;
            err_vaddr_l1 <= va_q;
            err_who_l1   <= who_q;
            st           <= S_RESP;
          end
        end
        S_L2_ISSUE: st <= S_L2_WAIT;
        S_L2_WAIT: if (mem_rvalid) begin
          if (mem_rdata[1]) begin
            rsp_paddr <= {mem_rdata[31:12], va_q[11:0]};
            rsp_perm  <= mem_rdata[7:4];
          end else begin
            f2_q         <= 1'b1;
            rsp_paddr    <= '0;
            rsp_perm     <= '0;
            err_vaddr_l2 <= va_q;
            err_who_l2   <= who_q;
          end
          st <= S_RESP;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R8: a read is never issued on two consecutive cycles
  p_one_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> !mem_rd);

  // R8: response is a single-cycle pulse and never overlaps readiness
  p_rsp_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_busy_on_rsp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  // R2 / R4: at most one level reports a fault, and a fault returns zero data
  p_fault_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $onehot0(rsp_status[17:16]));

  p_fault_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && (rsp_status[17:16] != 2'b00)) |-> (rsp_paddr == 32'b0 && rsp_perm == 4'b0));

  // R6: a second-level fault leaves a one-hot master matching the status word
  p_err_who_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status[17]) |-> ($onehot(err_who_l2) && 32'(err_who_l2) == rsp_status[15:0]));

  // R7: no read request while idle or responding
  p_no_rd_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready || rsp_valid) |-> !mem_rd);

endmodule

// File: tb/tb_iova_walker.sv
module tb_iova_walker;
  localparam int NM = 6;
  localparam int MW = $clog2(NM);
  localparam logic [31:0] BASE = 32'h0010_0400;

  logic clk = 1'b0, rst_n = 1'b0;
  logic xlat_en = 1'b0, req_valid = 1'b0, mem_rvalid = 1'b0;
  logic [31:0] req_vaddr = '0, mem_rdata = '0;
  logic [MW-1:0] req_master = '0;
  logic req_ready, rsp_valid, mem_rd;
  logic [31:0] rsp_paddr, rsp_status, mem_addr, err_vaddr_l1, err_vaddr_l2;
  logic [3:0] rsp_perm;
  logic [NM-1:0] err_who_l1, err_who_l2;

  always #2 clk = ~clk;

  iova_walker #(.NMASTER(NM)) dut (
    .clk(clk), .rst_n(rst_n), .xlat_en(xlat_en), .dir_base(BASE),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_master(req_master), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
    .rsp_perm(rsp_perm), .rsp_status(rsp_status), .mem_rd(mem_rd),
    .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .err_vaddr_l1(err_vaddr_l1), .err_vaddr_l2(err_vaddr_l2),
    .err_who_l1(err_who_l1), .err_who_l2(err_who_l2));

  logic [31:0] mem [int unsigned];
  int checks = 0, errors = 0, cyc = 0;
  int rd_total = 0, rsp_total = 0, pend_cnt = 0;
  bit pend = 0;
  logic [31:0] pend_addr;
  logic [31:0] rd_log [4];
  logic [31:0] e_va1 = '0, e_va2 = '0;
  logic [NM-1:0] e_who1 = '0, e_who2 = '0;

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  function automatic logic [31:0] pt_base(input int d);
    return 32'h0040_0000 + (d << 10);
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rsp_valid) rsp_total <= rsp_total + 1;
    mem_rvalid <= 1'b0;
    if (pend) begin
      if (pend_cnt == 0) begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= rd(pend_addr);
        pend       <= 0;
      end else pend_cnt <= pend_cnt - 1;
    end
    if (mem_rd) begin
      pend      <= 1;
      pend_cnt  <= $urandom_range(0, 3);
      pend_addr <= mem_addr;
      rd_log[rd_total % 4] <= mem_addr;
      rd_total  <= rd_total + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic xlat(input bit en, input logic [31:0] va, input int m);
    logic [31:0] a1, a2, d, p, e_pa, e_st;
    logic [3:0] e_perm;
    int e_nrd, s0, r0, t;
    e_nrd = 0; e_pa = va; e_perm = 0; e_st = 0; a1 = 0; a2 = 0;
    if (en) begin
      a1 = BASE + {18'b0, va[31:20], 2'b00};
      d = rd(a1); e_nrd = 1;
      if (d[1:0] != 2'b01) begin
        e_pa = 0; e_st = (32'd1 << 16) | (32'd1 << m);
        e_va1 = va; e_who1 = NM'(1) << m;
      end else begin
        a2 = {d[31:10], 10'b0} + {22'b0, va[19:12], 2'b00};
        p = rd(a2); e_nrd = 2;
        if (!p[1]) begin
          e_pa = 0; e_st = (32'd1 << 17) | (32'd1 << m);
          e_va2 = va; e_who2 = NM'(1) << m;
        end else begin
          e_pa = {p[31:12], va[11:0]}; e_perm = p[7:4];
        end
      end
    end
    while (!req_ready) @(negedge clk);
    xlat_en = en; req_valid = 1; req_vaddr = va; req_master = MW'(m);
    s0 = rd_total; r0 = rsp_total;
    @(negedge clk);
    req_vaddr = $urandom; req_master = MW'((m + 1) % NM); xlat_en = !en;
    t = 0;
    while (!rsp_valid && t < 100) begin @(negedge clk); t++; end
    req_valid = 0;
    chk(rsp_valid, "R8 response arrives", 64'(rsp_valid), 1);
    chk(rsp_paddr == e_pa, "R5 physical address", 64'(rsp_paddr), 64'(e_pa));
    chk(rsp_perm == e_perm, "R5 permission index", 64'(rsp_perm), 64'(e_perm));
    chk(rsp_status == e_st, "R2/R4/R6 status word", 64'(rsp_status), 64'(e_st));
    if (!en) chk(t == 0, "R7 bypass response next cycle", 64'(t), 0);
    if (e_nrd >= 1) chk(rd_log[s0 % 4] == a1, "R1 directory read address", 64'(rd_log[s0 % 4]), 64'(a1));
    if (e_nrd == 2) chk(rd_log[(s0 + 1) % 4] == a2, "R3 page read address", 64'(rd_log[(s0 + 1) % 4]), 64'(a2));
    chk(err_vaddr_l1 == e_va1 && err_who_l1 == e_who1, "R6 level-1 error registers",
        {err_vaddr_l1, 26'b0, err_who_l1}, {e_va1, 26'b0, e_who1});
    chk(err_vaddr_l2 == e_va2 && err_who_l2 == e_who2, "R6 level-2 error registers",
        {err_vaddr_l2, 26'b0, err_who_l2}, {e_va2, 26'b0, e_who2});
    @(negedge clk); @(negedge clk);
    chk(rd_total - s0 == e_nrd, "R7/R2 memory read count", 64'(rd_total - s0), 64'(e_nrd));
    chk(rsp_total - r0 == 1, "R8 one response per request", 64'(rsp_total - r0), 1);
  endtask

  always @(negedge clk) begin
    if (cyc == 150000) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int d = 0; d < 16; d++) begin
      logic [31:0] dte;
      if ($urandom_range(0, 9) < 7)
        dte = pt_base(d) | ({24'b0, 6'($urandom), 2'b01} << 0) & 32'hFFFF_FFFD | 32'h1;
      else
        dte = ($urandom & 32'hFFFF_FFFC) | 32'($urandom_range(0, 2) == 0 ? 0 : ($urandom_range(0, 1) ? 2 : 3));
      mem[BASE + 32'(d * 4)] = dte;
      for (int p = 0; p < 16; p++)
        mem[pt_base(d) + 32'(p * 4)] = ($urandom & 32'hFFFF_FFFD) | ($urandom_range(0, 3) != 0 ? 32'h2 : 32'h0);
    end
    mem[BASE + 32'(3 * 4)] = pt_base(3) | 32'h3;
    mem[BASE + 32'(4 * 4)] = pt_base(4) | 32'h2;
    mem[BASE + 32'(5 * 4)] = pt_base(5) | 32'h3FC | 32'h1;
    mem[pt_base(5) + 32'(7 * 4)] = 32'hABCDE_0A2;
    mem[pt_base(5) + 32'(8 * 4)] = 32'h12345_0F1;
    mem[BASE + 32'(4095 * 4)] = 32'h0090_0001;
    mem[32'h0090_0000 + 32'(255 * 4)] = 32'hFFFFF_0F2;

    repeat (3) @(negedge clk);
    chk(req_ready == 1 && rsp_valid == 0 && mem_rd == 0, "R9 reset handshake state",
        {61'b0, req_ready, rsp_valid, mem_rd}, 64'h4);
    chk(err_vaddr_l1 == 0 && err_vaddr_l2 == 0 && err_who_l1 == 0 && err_who_l2 == 0,
        "R9 reset error registers", {err_vaddr_l1, err_vaddr_l2}, 0);
    rst_n = 1;
    @(negedge clk);

    xlat(1, {12'd3, 8'd1, 12'h123}, 2);       // R2 code 11 invalid
    xlat(1, {12'd4, 8'd1, 12'h456}, 0);       // R2 code 10 invalid
    xlat(1, {12'd5, 8'd7, 12'h789}, 5);       // R2 ignored bits, R5 success
    xlat(1, {12'd5, 8'd8, 12'h001}, 1);       // R4 only bit 0 set
    xlat(1, {12'd4095, 8'd255, 12'hFFF}, 3);  // R1 top index, R3 top page
    xlat(1, {12'd2048, 8'd0, 12'h0}, 4);      // R2 absent entry reads 0
    xlat(0, 32'hDEAD_BEEF, 1);                // R7 bypass

    for (int i = 0; i < 300; i++) begin
      int d, p;
      d = $urandom_range(0, 17);
      if (d == 16) d = 4095; else if (d == 17) d = 2048;
      p = ($urandom_range(0, 9) == 0) ? 255 : $urandom_range(0, 15);
      xlat($urandom_range(0, 7) != 0, {12'(d), 8'(p), 12'($urandom)}, $urandom_range(0, NM - 1));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule